// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a processor from the moment an exception is detected to the moment the fetch of the handler's first instruction is issued. The core presents a request with a 4-bit exception type, a 4-bit fault-status code, the faulting and next program counters and, for interrupts, the pending priority level. The sequencer first updates the status register. It then obtains a vector number, either from a fixed table indexed by the type or, for interrupts, from an interrupt-acknowledge read on the bus. Next it pushes a two-longword frame onto the supervisor stack, reads the handler address from the vector table and pulses a fetch strobe with that address.

The block owns the status register and two stack pointers, one for user mode and one for supervisor mode. The core reads them through `sr_o` and `a7_o`, where `a7_o` is the pointer that matches the current mode. The core writes them through simple write strobes, which take effect only while the sequencer is idle. Every bus access uses one request/acknowledge handshake. The request and its fields stay steady until `bus_ack` arrives, with one exception: an acknowledge read that times out is dropped.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset the block is idle with `busy`=0 and `bus_req`=0. The status register reads 0x2700 (supervisor bit 13 set, priority mask bits 10:8 = 7), and `a7_o` shows the supervisor pointer reset value 0x0000_8000.
- R2: When `exc_req` is seen while idle, the old status register value is kept as the saved copy. From the next cycle the live register has bit 13 (supervisor) set and bit 15 (trace) cleared. For types other than interrupt, bit 12 and bits 10:8 are left unchanged.
- R3: For the interrupt type (7), bit 12 (master) is also cleared and bits 10:8 are loaded with `irq_level`.
- R4: For other types the vector comes from the type: 0→2, 1→3, 2→4, 3→5, 4→8, 5→9, 6→14, and 8..15→32..39.
- R5: For type 7 the block first runs a read with `bus_iack`=1 and `bus_we`=0 at address 0xFFFF_FFE0 + 4×level. The vector is bits 7:0 of the returned data.
- R6: If that acknowledge read gets no `bus_ack` within 16 cycles (`ACK_TIMEOUT`), the request is withdrawn after exactly 16 cycles and vector 24 is used.
- R7: The frame always goes on the supervisor stack pointer, even when the user pointer was active. The user pointer is never changed by an exception.
- R8: The frame base is the supervisor pointer rounded down to a multiple of 4. The 4-bit format field holds 4 plus the two bits removed. Afterwards the supervisor pointer equals the base minus 8.
- R9: The first frame write stores the saved PC at base−4. The second write stores, at base−8, the word {format[31:28], fault status bits 3:2 in [27:26], vector in [25:18], fault status bits 1:0 in [17:16], saved status register in [15:0]}.
- R10: The saved PC is the faulting PC for types 0, 1, 2, 3, 4 and 6. It is the next PC for type 5, type 7 and types 8..15.
- R11: After the frame, the block reads longword `vec_base` + 4×vector. It then raises `handler_valid` for exactly one cycle with `handler_addr` equal to the data read, and is idle on the following cycle.
- R12: A bus request holds `bus_addr`, `bus_we` and `bus_wdata` steady until it is acknowledged.
- R13: `exc_req` is ignored while a sequence is in progress. No second sequence and no extra bus cycle follow from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req | input | 1 | Exception request, taken when idle |
| exc_type | input | 4 | Exception type code (7 = interrupt) |
| exc_fs | input | 4 | Fault-status code for the frame |
| exc_fault_pc | input | 32 | Address of the faulting instruction |
| exc_next_pc | input | 32 | Address of the next instruction |
| irq_level | input | 3 | Interrupt level 1..7 being serviced |
| vec_base | input | 32 | Vector table base address |
| core_sr_we | input | 1 | Core write strobe for the status register |
| core_sr_wdata | input | 16 | Core write data for the status register |
| core_sp_we | input | 1 | Core write strobe for the active stack pointer |
| core_sp_wdata | input | 32 | Core write data for the active stack pointer |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | Bus write (1) or read (0) |
| bus_iack | output | 1 | Access is in the interrupt-acknowledge space |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus acknowledge, one cycle |
| bus_rdata | input | 32 | Bus read data, valid with `bus_ack` |
| handler_valid | output | 1 | One-cycle strobe to fetch the handler |
| handler_addr | output | 32 | Handler address |
| busy | output | 1 | Sequence in progress |
| sr_o | output | 16 | Current status register |
| a7_o | output | 32 | Stack pointer for the current mode |

## Verification
The bench targets several corner cases, each with a distinct failure signature:
- A misaligned supervisor pointer. A design that skipped the rounding would emit unaligned frame writes or a wrong format nibble.
- Entry from user mode with a distinct user pointer. A design that pushed onto the active pointer would corrupt the user stack.
- A silent acknowledge read. This exposes a sequencer that hangs, or that leaves the request up for the wrong number of cycles, or that loads a vector other than 24.
- Random status register contents, including a set trace bit and a set master bit. These show whether the interrupt-only updates leak into other types or are missing for interrupts.
- A second request raised during a sequence. This exposes a design that re-enters.

// File: rtl/exc_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, state type and the type-to-vector mapping
// used by the exception entry sequencer.
package exc_seq_pkg;

    localparam int SR_T_BIT   = 15;
    localparam int SR_S_BIT   = 13;
    localparam int SR_M_BIT   = 12;
    localparam int SR_IPL_LO  = 8;

    localparam logic [3:0] TY_INTR      = 4'd7;
    localparam logic [7:0] VEC_SPURIOUS = 8'd24;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IACK,
        ST_PUSH_PC,
        ST_PUSH_SR,
        ST_VREAD,
        ST_FETCH
    } seq_state_e;

    // Vector number for every non-interrupt exception type.
    function automatic logic [7:0] vector_of_type(input logic [3:0] ty);
        logic [7:0] v;
        case (ty)
            4'd0:    v = 8'd2;
            4'd1:    v = 8'd3;
            4'd2:    v = 8'd4;
            4'd3:    v = 8'd5;
            4'd4:    v = 8'd8;
            4'd5:    v = 8'd9;
            4'd6:    v = 8'd14;
            4'd7:    v = VEC_SPURIOUS;
            default: v = 8'd32 + {5'd0, ty[2:0]};
        endcase
        return v;
    endfunction

    // True when the frame must carry the faulting PC (restart model).
    function automatic logic saves_fault_pc(input logic [3:0] ty);
        return (ty <= 4'd4) || (ty == 4'd6);
    endfunction

endpackage

// File: rtl/exc_ctx_regs.sv
`timescale 1ns/1ps
// Context registers: status register plus separate user and supervisor
// stack pointers. The sequencer's updates take priority; core writes are
// dropped while the sequencer holds the context. Assumes the sequencer
// never writes the user pointer.
module exc_ctx_regs
    import exc_seq_pkg::*;
#(
    parameter logic [15:0] SR_RESET  = 16'h2700,
    parameter logic [31:0] SSP_RESET = 32'h0000_8000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        seq_hold,
    input  logic        seq_sr_we,
    input  logic [15:0] seq_sr_val,
    input  logic        seq_ssp_we,
    input  logic [31:0] seq_ssp_val,
    input  logic        core_sr_we,
    input  logic [15:0] core_sr_wdata,
    input  logic        core_sp_we,
    input  logic [31:0] core_sp_wdata,
    output logic [15:0] sr_q,
    output logic [31:0] ssp_q,
    output logic [31:0] usp_q,
    output logic [31:0] a7_q
);

    logic core_ok;
    logic in_super;

    assign core_ok  = !seq_hold;
    assign in_super = sr_q[SR_S_BIT];

    // Status register: sequencer update first, otherwise a core write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= SR_RESET;
        end else if (seq_sr_we) begin
            sr_q <= seq_sr_val;
        end else if (core_sr_we && core_ok) begin
            sr_q <= core_sr_wdata;
        end
    end

    // Supervisor pointer: frame push result, or a core write in supervisor mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ssp_q <= SSP_RESET;
        end else if (seq_ssp_we) begin
            ssp_q <= seq_ssp_val;
        end else if (core_sp_we && core_ok && in_super) begin
            ssp_q <= core_sp_wdata;
        end
    end

    // User pointer: written only by the core while in user mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            usp_q <= '0;
        end else if (core_sp_we && core_ok && !in_super) begin
            usp_q <= core_sp_wdata;
        end
    end

    // Mode-selected pointer seen by the core.
    always_comb begin
        a7_q = in_super ? ssp_q : usp_q;
    end

    // R7: an exception never disturbs the user stack pointer.
    p_usp_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_hold |=> $stable(usp_q));

endmodule

// File: rtl/exc_ack_timer.sv
`timescale 1ns/1ps
// Acknowledge watchdog: counts the cycles an interrupt-acknowledge read
// waits and flags expiry in its LIMIT-th cycle when no ack arrives.
// Assumes run drops right after expiry or an ack.
module exc_ack_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ack,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Count waiting cycles; clear whenever the read is not pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run && !ack && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    // Expiry in the last permitted waiting cycle.
    always_comb begin
        expired = run && !ack && (cnt_q == CW'(LIMIT - 1));
    end

    // R6: the wait counter never passes the limit.
    p_timer_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT));

endmodule

// File: rtl/exc_frame_word.sv
`timescale 1ns/1ps
// Frame word builder: packs format, fault status, vector and saved
// status register into the lower-address frame longword.
module exc_frame_word (
    input  logic [1:0]  misalign,
    input  logic [3:0]  fs,
    input  logic [7:0]  vector,
    input  logic [15:0] sr_saved,
    output logic [31:0] word
);

    logic [3:0] fmt;

    // Format nibble is 4 plus the bytes dropped by alignment.
    always_comb begin
        fmt  = 4'd4 + {2'b00, misalign};
        word = {fmt, fs[3:2], vector, fs[1:0], sr_saved};
    end

endmodule

// File: rtl/exc_entry_seq.sv
`timescale 1ns/1ps
// Exception entry sequencer: on a request, updates the status register,
// obtains the vector (from the type or an acknowledge read), pushes a
// two-longword frame on the supervisor stack, reads the vector table and
// pulses the handler fetch. Assumes exc_* inputs are valid with exc_req,
// irq_level is 1..7 for interrupts, and vec_base is steady while busy.
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int          ACK_TIMEOUT = 16,
    parameter logic [31:0] SSP_RESET   = 32'h0000_8000,
    parameter logic [15:0] SR_RESET    = 16'h2700,
    parameter logic [31:0] IACK_BASE   = 32'hFFFF_FFE0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        exc_req,
    input  logic [3:0]  exc_type,
    input  logic [3:0]  exc_fs,
    input  logic [31:0] exc_fault_pc,
    input  logic [31:0] exc_next_pc,
    input  logic [2:0]  irq_level,
    input  logic [31:0] vec_base,
    input  logic        core_sr_we,
    input  logic [15:0] core_sr_wdata,
    input  logic        core_sp_we,
    input  logic [31:0] core_sp_wdata,
    output logic        bus_req,
    output logic        bus_we,
    output logic        bus_iack,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic        bus_ack,
    input  logic [31:0] bus_rdata,
    output logic        handler_valid,
    output logic [31:0] handler_addr,
    output logic        busy,
    output logic [15:0] sr_o,
    output logic [31:0] a7_o
);

    localparam logic [31:0] FRAME_BYTES = 32'd8;
    localparam logic [31:0] WORD_BYTES  = 32'd4;

    seq_state_e  state_q;
    logic [3:0]  fs_q;
    logic [2:0]  lvl_q;
    logic [7:0]  vec_q;
    logic [15:0] sr_saved_q;
    logic [31:0] pc_q;
    logic [31:0] base_q;
    logic [1:0]  off_q;
    logic [31:0] handler_q;

    logic        accept;
    logic        is_intr;
    logic [15:0] sr_cur;
    logic [15:0] sr_entry;
    logic [31:0] ssp_cur;
    logic [31:0] usp_cur;
    logic        ssp_we;
    logic        ack_expired;
    logic [31:0] frame_word;

    assign accept  = (state_q == ST_IDLE) && exc_req;
    assign is_intr = (exc_type == TY_INTR);
    assign ssp_we  = (state_q == ST_PUSH_SR) && bus_ack;

    // Status register value taken on entry.
    always_comb begin
        sr_entry = sr_cur;
        sr_entry[SR_S_BIT] = 1'b1;
        sr_entry[SR_T_BIT] = 1'b0;
        if (is_intr) begin
            sr_entry[SR_M_BIT] = 1'b0;
            sr_entry[SR_IPL_LO +: 3] = irq_level;
        end
    end

    exc_ctx_regs #(
        .SR_RESET  (SR_RESET),
        .SSP_RESET (SSP_RESET)
    ) u_ctx (
        .clk           (clk),
        .rst_n         (rst_n),
        .seq_hold      (busy || accept),
        .seq_sr_we     (accept),
        .seq_sr_val    (sr_entry),
        .seq_ssp_we    (ssp_we),
        .seq_ssp_val   (base_q - FRAME_BYTES),
        .core_sr_we    (core_sr_we),
        .core_sr_wdata (core_sr_wdata),
        .core_sp_we    (core_sp_we),
        .core_sp_wdata (core_sp_wdata),
        .sr_q          (sr_cur),
        .ssp_q         (ssp_cur),
        .usp_q         (usp_cur),
        .a7_q          (a7_o)
    );

    exc_ack_timer #(
        .LIMIT (ACK_TIMEOUT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_IACK),
        .ack     (bus_ack),
        .expired (ack_expired)
    );

    exc_frame_word u_frame (
        .misalign (off_q),
        .fs       (fs_q),
        .vector   (vec_q),
        .sr_saved (sr_saved_q),
        .word     (frame_word)
    );

    // Sequencer state and per-exception context capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            fs_q       <= '0;
            lvl_q      <= '0;
            vec_q      <= '0;
            sr_saved_q <= '0;
            pc_q       <= '0;
            base_q     <= '0;
            off_q      <= '0;
            handler_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (exc_req) begin
                        fs_q       <= exc_fs;
                        lvl_q      <= irq_level;
                        vec_q      <= vector_of_type(exc_type);
                        sr_saved_q <= sr_cur;
                        pc_q       <= saves_fault_pc(exc_type) ? exc_fault_pc : exc_next_pc;
                        base_q     <= {ssp_cur[31:2], 2'b00};
                        off_q      <= ssp_cur[1:0];
                        state_q    <= is_intr ? ST_IACK : ST_PUSH_PC;
                    end
                end
                ST_IACK: begin
                    if (bus_ack) begin
                        vec_q   <= bus_rdata[7:0];
                        state_q <= ST_PUSH_PC;
                    end else if (ack_expired) begin
                        vec_q   <= VEC_SPURIOUS;
                        state_q <= ST_PUSH_PC;
                    end
                end
                ST_PUSH_PC: begin
                    if (bus_ack) state_q <= ST_PUSH_SR;
                end
                ST_PUSH_SR: begin
                    if (bus_ack) state_q <= ST_VREAD;
                end
                ST_VREAD: begin
                    if (bus_ack) begin
                        handler_q <= bus_rdata;
                        state_q   <= ST_FETCH;
                    end
                end
                ST_FETCH: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Bus request fields for the current step.
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_iack  = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        case (state_q)
            ST_IACK: begin
                bus_req  = 1'b1;
                bus_iack = 1'b1;
                bus_addr = IACK_BASE | {27'd0, lvl_q, 2'b00};
            end
            ST_PUSH_PC: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = base_q - WORD_BYTES;
                bus_wdata = pc_q;
            end
            ST_PUSH_SR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = base_q - FRAME_BYTES;
                bus_wdata = frame_word;
            end
            ST_VREAD: begin
                bus_req  = 1'b1;
                bus_addr = vec_base + {22'd0, vec_q, 2'b00};
            end
            default: ;
        endcase
    end

    // Status outputs toward the core.
    always_comb begin
        busy          = (state_q != ST_IDLE);
        handler_valid = (state_q == ST_FETCH);
        handler_addr  = handler_q;
        sr_o          = sr_cur;
    end

    // R12: a pending request keeps its fields until acknowledged.
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !ack_expired) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R8: frame writes land on longword boundaries.
    p_frame_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |-> (bus_addr[1:0] == 2'b00));

    // R2: entering a sequence leaves supervisor set and trace clear.
    p_entry_sr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (sr_o[SR_S_BIT] && !sr_o[SR_T_BIT]));

    // R11: the fetch strobe is a single cycle and ends the sequence.
    p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        handler_valid |=> (!handler_valid && !busy));

    // R5: acknowledge accesses are reads.
    p_iack_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_iack |-> (bus_req && !bus_we));

endmodule

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb;

    localparam int          ACK_TO  = 16;
    localparam logic [31:0] SSP_RST = 32'h0000_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [3:0]  exc_type = '0;
    logic [3:0]  exc_fs = '0;
    logic [31:0] exc_fault_pc = '0;
    logic [31:0] exc_next_pc = '0;
    logic [2:0]  irq_level = '0;
    logic [31:0] vec_base = 32'h0001_0000;
    logic        core_sr_we = 1'b0;
    logic [15:0] core_sr_wdata = '0;
    logic        core_sp_we = 1'b0;
    logic [31:0] core_sp_wdata = '0;
    logic        bus_req, bus_we, bus_iack;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        handler_valid;
    logic [31:0] handler_addr;
    logic        busy;
    logic [15:0] sr_o;
    logic [31:0] a7_o;

    int checks = 0;
    int errors = 0;

    exc_entry_seq #(.ACK_TIMEOUT(ACK_TO), .SSP_RESET(SSP_RST)) u_dut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_type(exc_type),
        .exc_fs(exc_fs), .exc_fault_pc(exc_fault_pc), .exc_next_pc(exc_next_pc),
        .irq_level(irq_level), .vec_base(vec_base), .core_sr_we(core_sr_we),
        .core_sr_wdata(core_sr_wdata), .core_sp_we(core_sp_we),
        .core_sp_wdata(core_sp_wdata), .bus_req(bus_req), .bus_we(bus_we),
        .bus_iack(bus_iack), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .handler_valid(handler_valid),
        .handler_addr(handler_addr), .busy(busy), .sr_o(sr_o), .a7_o(a7_o)
    );

    always #2.5 clk = ~clk;

    // ---------------- reference model state ----------------
    logic [15:0] m_sr  = 16'h2700;
    logic [31:0] m_ssp = SSP_RST;
    logic [31:0] m_usp = '0;

    // ---------------- bus slave and log ----------------
    logic        iack_mute = 1'b0;
    logic [7:0]  iack_vec  = 8'd64;
    logic        log_we[8];
    logic        log_iack[8];
    logic [31:0] log_addr[8];
    logic [31:0] log_data[8];
    int          log_n = 0;
    int          hold_bad = 0;
    int          iack_cycles = 0;

    function automatic logic [31:0] tbl(input logic [31:0] a);
        return a ^ 32'hA5A5_0000;
    endfunction

    function automatic logic [7:0] exp_vec(input logic [3:0] t);
        case (t)
            4'd0: return 8'd2;
            4'd1: return 8'd3;
            4'd2: return 8'd4;
            4'd3: return 8'd5;
            4'd4: return 8'd8;
            4'd5: return 8'd9;
            4'd6: return 8'd14;
            4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15:
                  return 8'd32 + 8'(t - 4'd8);
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic exp_fault(input logic [3:0] t);
        return (t == 4'd0) || (t == 4'd1) || (t == 4'd2) || (t == 4'd3) ||
               (t == 4'd4) || (t == 4'd6);
    endfunction

    function automatic logic [15:0] exp_sr(input logic [15:0] s, input logic [3:0] t,
                                           input logic [2:0] l);
        logic [15:0] r;
        r = s;
        r[13] = 1'b1;
        r[15] = 1'b0;
        if (t == 4'd7) begin
            r[12] = 1'b0;
            r[10:8] = l;
        end
        return r;
    endfunction

    // Slave: random latency, ack for one cycle, logs every completed access.
    initial begin
        int wait_cnt;
        int delay;
        logic pending;
        logic [31:0] a0, d0;
        logic w0;
        wait_cnt = 0; delay = 1; pending = 1'b0; a0 = '0; d0 = '0; w0 = 1'b0;
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req && !(bus_iack && iack_mute)) begin
                if (!pending) begin
                    pending = 1'b1; wait_cnt = 0;
                    a0 = bus_addr; d0 = bus_wdata; w0 = bus_we;
                end
                if (wait_cnt < delay) begin
                    wait_cnt++;
                end else begin
                    if (bus_addr !== a0 || bus_wdata !== d0 || bus_we !== w0) hold_bad++;
                    bus_ack = 1'b1;
                    bus_rdata = bus_iack ? {24'd0, iack_vec} : (bus_we ? 32'd0 : tbl(bus_addr));
                    if (log_n < 8) begin
                        log_we[log_n] = bus_we; log_iack[log_n] = bus_iack;
                        log_addr[log_n] = bus_addr; log_data[log_n] = bus_wdata;
                    end
                    log_n++;
                    pending = 1'b0;
                    delay = $urandom % 4;
                end
            end
        end
    end

    // Monitor: counts acknowledge-space request cycles.
    always @(negedge clk) begin
        if (bus_req && bus_iack) iack_cycles++;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_sr(input logic [15:0] v);
        @(negedge clk);
        core_sr_we = 1'b1; core_sr_wdata = v;
        @(negedge clk);
        core_sr_we = 1'b0;
        m_sr = v;
    endtask

    task automatic set_sp(input logic [31:0] v);
        @(negedge clk);
        core_sp_we = 1'b1; core_sp_wdata = v;
        @(negedge clk);
        core_sp_we = 1'b0;
        if (m_sr[13]) m_ssp = v; else m_usp = v;
    endtask

    // One exception from request to handler strobe, fully checked.
    task automatic run_exc(input logic [3:0] ty, input logic [2:0] lvl,
                           input logic mute, input logic dup);
        logic [31:0] base, pc, vaddr, fw;
        logic [7:0]  vec;
        logic [1:0]  off;
        logic [3:0]  fs;
        logic        intr;
        int          idx, n, exp_n;
        intr = (ty == 4'd7);
        fs   = 4'($urandom);
        @(negedge clk);
        exc_type = ty; exc_fs = fs; irq_level = lvl; iack_mute = mute;
        exc_fault_pc = $urandom; exc_next_pc = $urandom;
        iack_vec = 8'd64 + 8'($urandom % 128);
        log_n = 0; iack_cycles = 0;
        exc_req = 1'b1;
        @(negedge clk);
        exc_req = dup;
        chk(intr ? "R3 sr on interrupt entry" : "R2 sr on entry", {16'd0, sr_o},
            {16'd0, exp_sr(m_sr, ty, lvl)});
        n = 0;
        while (!handler_valid && n < 400) begin
            @(negedge clk);
            n++;
            if (n >= 3) exc_req = 1'b0;
        end
        exc_req = 1'b0;
        off  = m_ssp[1:0];
        base = {m_ssp[31:2], 2'b00};
        pc   = exp_fault(ty) ? exc_fault_pc : exc_next_pc;
        vec  = intr ? (mute ? 8'd24 : iack_vec) : exp_vec(ty);
        fw   = {4'd4 + {2'b00, off}, fs[3:2], vec, fs[1:0], m_sr};
        vaddr = vec_base + {22'd0, vec, 2'b00};
        idx = 0;
        if (intr && !mute) begin
            chk("R5 iack access flags", {30'd0, log_iack[0], log_we[0]}, 32'd2);
            chk("R5 iack address", log_addr[0], 32'hFFFF_FFE0 + 32'(lvl) * 4);
            idx = 1;
        end
        if (intr && mute)
            chk("R6 iack request length", 32'(iack_cycles), 32'(ACK_TO));
        exp_n = idx + 3;
        chk("R13 bus access count", 32'(log_n), 32'(exp_n));
        chk("R9 pc push address", log_addr[idx], base - 32'd4);
        chk("R10 saved pc", log_data[idx], pc);
        chk("R9 format word address", log_addr[idx+1], base - 32'd8);
        chk(intr ? "R8 R6 format word" : "R8 R4 format word", log_data[idx+1], fw);
        chk("R11 vector read address", {31'd0, log_we[idx+2]} | log_addr[idx+2], vaddr);
        chk("R11 handler address", handler_addr, tbl(vaddr));
        @(negedge clk);
        chk("R11 idle after strobe", {30'd0, busy, handler_valid}, 32'd0);
        m_sr  = exp_sr(m_sr, ty, lvl);
        m_ssp = base - 32'd8;
        chk("R8 R7 supervisor pointer after frame", a7_o, m_ssp);
        if (dup) begin
            repeat (6) begin
                @(negedge clk);
                chk("R13 no re-entry", {30'd0, busy, bus_req}, 32'd0);
            end
        end
        iack_mute = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset sr", {16'd0, sr_o}, 32'h0000_2700);
        chk("R1 reset a7", a7_o, SSP_RST);
        chk("R1 reset idle", {30'd0, busy, bus_req}, 32'd0);

        // Directed: aligned pointer, restart-type fault.
        run_exc(4'd2, 3'd0, 1'b0, 1'b0);
        // Directed: misaligned pointer, trace (next PC).
        set_sp(32'h0000_7F03);
        run_exc(4'd5, 3'd0, 1'b0, 1'b0);
        // Directed: interrupt with acknowledge, master and trace set beforehand.
        set_sr(16'hB300);
        run_exc(4'd7, 3'd3, 1'b0, 1'b0);
        // Directed: silent acknowledge -> spurious vector.
        run_exc(4'd7, 3'd7, 1'b1, 1'b0);
        // Directed: entry from user mode with its own pointer.
        set_sr(16'h0000);
        set_sp(32'h1234_5670);
        run_exc(4'd9, 3'd0, 1'b0, 1'b0);
        set_sr(16'h0000);
        @(negedge clk);
        chk("R7 user pointer untouched", a7_o, m_usp);
        set_sr(16'h2000);
        // Directed: second request during a sequence.
        run_exc(4'd3, 3'd0, 1'b0, 1'b1);

        // Random mix.
        for (int i = 0; i < 40; i++) begin
            logic [3:0] t;
            logic [2:0] l;
            t = 4'($urandom);
            l = 3'(1 + ($urandom % 7));
            if (($urandom % 3) == 0) set_sr(16'($urandom));
            if (($urandom % 3) == 0) set_sp(32'h0000_4000 + ($urandom % 32'h3000));
            vec_base = {$urandom, 10'd0} & 32'hFFFF_FC00;
            run_exc(t, l, (t == 4'd7) && (($urandom % 4) == 0), ($urandom % 5) == 0);
        end

        chk("R12 request fields held until ack", 32'(hold_bad), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule